// File: doc/BRIEF.md
# Segmented Kernel Address Translator

This block is the address front end that sits ahead of a page TLB. For each accepted request it takes a virtual address, the kind of access (read, write or execute) and a user/kernel flag. It then picks one of three ways to produce a physical address, a permission set, a fault flag and a vector number.

When the global configuration word turns translation off, the virtual address is passed straight through with every permission granted. When translation is on, the top four address bits name one of sixteen segments. A privileged access to a segment that the MMU configuration word marks as directly mapped does not use paging. Its top nibble is replaced by a 4-bit physical base, and the sixteen bases are packed as nibbles into two base registers. Every other access is forwarded to the page TLB, to the instruction TLB for execute and to the data TLB otherwise. The front end waits for the TLB's completion handshake and returns the TLB's answer unchanged.

A direct result (pass-through or segment) is available one cycle after the request. A TLB result is available one cycle after the completion handshake. Requests that arrive while a TLB lookup is outstanding are not accepted.

Top module: `segKernXlate`

## Requirements
- R1: After reset, `rspValid` and `tlbReq` are both 0.
- R2: Translation is on when bit 2 or bit 3 (or both) of `globalCfg` is 1. When both are 0, the cycle after a request gives `rspValid`=1, `rspPaddr`=`vaddr`, `rspPerm`=3'b111 (bit 0 read, bit 1 write, bit 2 execute), `rspFault`=0 and `rspVec`=0, whatever the mode or segment.
- R3: With translation on, the segment number is `vaddr[31:28]`. A request is direct-mapped when `mmuCfg[segment]`=1 and `userMode`=0. The cycle after the request it gives `rspPaddr` = {segment base nibble, `vaddr[27:0]`}, `rspPerm`=3'b111, `rspFault`=0, `rspVec`=0, and no TLB request.
- R4: The base nibble for segment s in 0..7 is `baseLo[4s+3:4s]`. For s in 8..15 it is `baseHi[4(s-8)+3:4(s-8)]`.
- R5: A user-mode request never takes the direct mapping, even when its segment bit in `mmuCfg` is set. It goes to the TLB.
- R6: A request that is neither passed through nor direct-mapped raises `tlbReq` the cycle after it is accepted. `tlbVaddr`, `tlbKind` and `tlbUser` carry the request and hold steady until `tlbDone` is sampled.
- R7: `accKind` encodes 0 read, 1 write, 2 execute. `tlbInstr` is 1 exactly when the forwarded kind is 2.
- R8: The cycle after `tlbDone` is sampled high while `tlbReq` is 1, `rspValid`=1, the response carries `tlbFault`, `tlbPaddr`, `tlbPerm` and `tlbVec`, and `tlbReq` returns to 0.
- R9: Every accepted request produces exactly one response cycle.
- R10: `reqValid` is ignored while a TLB lookup is outstanding, including the cycle in which `tlbDone` arrives. It produces no response and no new TLB request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| accKind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| userMode | input | 1 | 1 for an unprivileged access |
| globalCfg | input | 32 | Global configuration; bits 2 and 3 enable translation |
| mmuCfg | input | 32 | Bit s marks segment s as directly mapped |
| baseLo | input | 32 | Base nibbles of segments 0 to 7 |
| baseHi | input | 32 | Base nibbles of segments 8 to 15 |
| tlbReq | output | 1 | Lookup outstanding at the page TLB |
| tlbInstr | output | 1 | Selects the instruction TLB |
| tlbVaddr | output | 32 | Address forwarded to the TLB |
| tlbKind | output | 2 | Access kind forwarded to the TLB |
| tlbUser | output | 1 | Mode forwarded to the TLB |
| tlbDone | input | 1 | TLB completion handshake |
| tlbFault | input | 1 | TLB fault result |
| tlbPaddr | input | 32 | TLB physical address |
| tlbPerm | input | 3 | TLB permission set |
| tlbVec | input | 4 | TLB fault vector |
| rspValid | output | 1 | Result strobe |
| rspFault | output | 1 | Fault flag |
| rspPaddr | output | 32 | Physical address |
| rspPerm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| rspVec | output | 4 | Fault vector number |

## Verification
The TLB's completion and a fresh request can land in the same cycle. In that cycle the block must finish the old lookup and must not accept the new request. The bench provokes this by holding `reqValid` high, with translation switched off so that an accepted request would answer at once, through every cycle of a three-cycle TLB wait, including the cycle in which its TLB model raises `tlbDone`. It then checks that only the TLB's answer comes out and that no extra response appears in the idle cycles after it.

// File: rtl/segKernXlatePkg.sv
`timescale 1ns/1ps
package segKernXlatePkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch request for the TLB path
    logic loadDirect;  // load pass-through / segment result
    logic loadTlb;     // load TLB result
  } xlateStrobe_t;

endpackage

// File: rtl/xlateControl.sv
`timescale 1ns/1ps
module xlateControl
  import segKernXlatePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         directHit,
  input  logic         tlbDone,
  output xlateStrobe_t strobe,
  output logic         tlbReq,
  output logic         rspValid
);

  typedef enum logic {ST_IDLE, ST_WAIT} ctlState_e;
  ctlState_e state;

  logic isIdle;
  assign isIdle = (state == ST_IDLE);

  always_comb begin
    strobe.capture    = isIdle && reqValid && !directHit;
    strobe.loadDirect = isIdle && reqValid && directHit;
    strobe.loadTlb    = !isIdle && tlbDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      rspValid <= strobe.loadDirect || strobe.loadTlb;
      case (state)
        ST_IDLE: if (strobe.capture) state <= ST_WAIT;
        ST_WAIT: if (tlbDone)        state <= ST_IDLE;
        default:                     state <= ST_IDLE;
      endcase
    end
  end

  assign tlbReq = !isIdle;

  AST_DIRECT_NO_TLB: assert property (@(posedge clk) disable iff (!rstN)
    (!tlbReq && reqValid && directHit) |=> (rspValid && !tlbReq)); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (tlbReq && !tlbDone) |=> (tlbReq && !rspValid)); // R10
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (tlbReq && tlbDone) |=> (!tlbReq && rspValid)); // R8
  AST_TLB_START: assert property (@(posedge clk) disable iff (!rstN)
    (!tlbReq && reqValid && !directHit) |=> (tlbReq && !rspValid)); // R6

endmodule

// File: rtl/xlateDatapath.sv
`timescale 1ns/1ps
module xlateDatapath
  import segKernXlatePkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          SEG_W   = 4,
  parameter int          CFG_W   = 32,
  parameter int          PERM_W  = 3,
  parameter int          VEC_W   = 4,
  parameter logic [31:0] EN_MASK = 32'h0000_000C
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  xlateStrobe_t                        strobe,
  input  logic [ADDR_W-1:0]                   vaddr,
  input  logic [1:0]                          accKind,
  input  logic                                userMode,
  input  logic [CFG_W-1:0]                    globalCfg,
  input  logic [CFG_W-1:0]                    mmuCfg,
  input  logic [((2**SEG_W)/2)*SEG_W-1:0]     baseLo,
  input  logic [((2**SEG_W)/2)*SEG_W-1:0]     baseHi,
  output logic                                directHit,
  output logic [ADDR_W-1:0]                   tlbVaddr,
  output logic [1:0]                          tlbKind,
  output logic                                tlbUser,
  output logic                                tlbInstr,
  input  logic                                tlbFault,
  input  logic [ADDR_W-1:0]                   tlbPaddr,
  input  logic [PERM_W-1:0]                   tlbPerm,
  input  logic [VEC_W-1:0]                    tlbVec,
  output logic                                rspFault,
  output logic [ADDR_W-1:0]                   rspPaddr,
  output logic [PERM_W-1:0]                   rspPerm,
  output logic [VEC_W-1:0]                    rspVec
);

  localparam int NUM_SEG  = 2 ** SEG_W;
  localparam int HALF_SEG = NUM_SEG / 2;
  localparam int OFF_W    = ADDR_W - SEG_W;

  // unpack the segment base nibbles from both registers
  logic [SEG_W-1:0] segBase [NUM_SEG];
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_base
    if (g < HALF_SEG) begin : g_lo
      assign segBase[g] = baseLo[g*SEG_W +: SEG_W];
    end else begin : g_hi
      assign segBase[g] = baseHi[(g-HALF_SEG)*SEG_W +: SEG_W];
    end
  end

  logic             xlateOn;
  logic [SEG_W-1:0] segIdx;
  logic             segMapped;
  logic [ADDR_W-1:0] directPaddr;

  assign xlateOn   = |(globalCfg & CFG_W'(EN_MASK));
  assign segIdx    = vaddr[ADDR_W-1 -: SEG_W];
  assign segMapped = mmuCfg[segIdx] && !userMode;
  assign directHit = !xlateOn || segMapped;
  assign directPaddr = xlateOn ? {segBase[segIdx], vaddr[OFF_W-1:0]} : vaddr;

  accKind_e reqKind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlbVaddr <= '0;
      reqKind  <= ACC_READ;
      tlbUser  <= 1'b0;
    end else if (strobe.capture) begin
      tlbVaddr <= vaddr;
      reqKind  <= accKind_e'(accKind);
      tlbUser  <= userMode;
    end
  end

  assign tlbKind  = reqKind;
  assign tlbInstr = (reqKind == ACC_EXEC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspFault <= 1'b0;
      rspPaddr <= '0;
      rspPerm  <= '0;
      rspVec   <= '0;
    end else if (strobe.loadDirect) begin
      rspFault <= 1'b0;
      rspPaddr <= directPaddr;
      rspPerm  <= '1;
      rspVec   <= '0;
    end else if (strobe.loadTlb) begin
      rspFault <= tlbFault;
      rspPaddr <= tlbPaddr;
      rspPerm  <= tlbPerm;
      rspVec   <= tlbVec;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadDirect && !xlateOn) |=>
      (rspPaddr == $past(vaddr) && rspPerm == '1 && !rspFault)); // R2
  AST_SEG_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadDirect && xlateOn) |=>
      (rspPaddr[OFF_W-1:0] == $past(vaddr[OFF_W-1:0]) && !rspFault)); // R3
  AST_USER_NOT_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadDirect && xlateOn) |-> !userMode); // R5

endmodule

// File: rtl/segKernXlate.sv
`timescale 1ns/1ps
module segKernXlate
  import segKernXlatePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int PERM_W = 3,
  parameter int VEC_W  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic [ADDR_W-1:0]               vaddr,
  input  logic [1:0]                      accKind,
  input  logic                            userMode,
  input  logic [CFG_W-1:0]                globalCfg,
  input  logic [CFG_W-1:0]                mmuCfg,
  input  logic [((2**SEG_W)/2)*SEG_W-1:0] baseLo,
  input  logic [((2**SEG_W)/2)*SEG_W-1:0] baseHi,
  output logic                            tlbReq,
  output logic                            tlbInstr,
  output logic [ADDR_W-1:0]               tlbVaddr,
  output logic [1:0]                      tlbKind,
  output logic                            tlbUser,
  input  logic                            tlbDone,
  input  logic                            tlbFault,
  input  logic [ADDR_W-1:0]               tlbPaddr,
  input  logic [PERM_W-1:0]               tlbPerm,
  input  logic [VEC_W-1:0]                tlbVec,
  output logic                            rspValid,
  output logic                            rspFault,
  output logic [ADDR_W-1:0]               rspPaddr,
  output logic [PERM_W-1:0]               rspPerm,
  output logic [VEC_W-1:0]                rspVec
);

  xlateStrobe_t strobe;
  logic         directHit;

  xlateControl u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .directHit (directHit),
    .tlbDone   (tlbDone),
    .strobe    (strobe),
    .tlbReq    (tlbReq),
    .rspValid  (rspValid)
  );

  xlateDatapath #(
    .ADDR_W (ADDR_W),
    .SEG_W  (SEG_W),
    .CFG_W  (CFG_W),
    .PERM_W (PERM_W),
    .VEC_W  (VEC_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .vaddr     (vaddr),
    .accKind   (accKind),
    .userMode  (userMode),
    .globalCfg (globalCfg),
    .mmuCfg    (mmuCfg),
    .baseLo    (baseLo),
    .baseHi    (baseHi),
    .directHit (directHit),
    .tlbVaddr  (tlbVaddr),
    .tlbKind   (tlbKind),
    .tlbUser   (tlbUser),
    .tlbInstr  (tlbInstr),
    .tlbFault  (tlbFault),
    .tlbPaddr  (tlbPaddr),
    .tlbPerm   (tlbPerm),
    .tlbVec    (tlbVec),
    .rspFault  (rspFault),
    .rspPaddr  (rspPaddr),
    .rspPerm   (rspPerm),
    .rspVec    (rspVec)
  );

  AST_TLB_ARGS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (tlbReq && !tlbDone) |=>
      ($stable(tlbVaddr) && $stable(tlbKind) && $stable(tlbUser))); // R6
  AST_INSTR_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    tlbReq |-> (tlbInstr == (tlbKind == 2'd2))); // R7

endmodule

// File: tb/test_segKernXlate.sv
`timescale 1ns/1ps
module test_segKernXlate;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        reqValid;
  logic [31:0] vaddr;
  logic [1:0]  accKind;
  logic        userMode;
  logic [31:0] globalCfg, mmuCfg, baseLo, baseHi;
  logic        tlbReq, tlbInstr, tlbUser;
  logic [31:0] tlbVaddr;
  logic [1:0]  tlbKind;
  logic        tlbDone, tlbFault;
  logic [31:0] tlbPaddr;
  logic [2:0]  tlbPerm;
  logic [3:0]  tlbVec;
  logic        rspValid, rspFault;
  logic [31:0] rspPaddr;
  logic [2:0]  rspPerm;
  logic [3:0]  rspVec;

  segKernXlate i_segKernXlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .accKind(accKind), .userMode(userMode), .globalCfg(globalCfg),
    .mmuCfg(mmuCfg), .baseLo(baseLo), .baseHi(baseHi),
    .tlbReq(tlbReq), .tlbInstr(tlbInstr), .tlbVaddr(tlbVaddr),
    .tlbKind(tlbKind), .tlbUser(tlbUser), .tlbDone(tlbDone),
    .tlbFault(tlbFault), .tlbPaddr(tlbPaddr), .tlbPerm(tlbPerm),
    .tlbVec(tlbVec), .rspValid(rspValid), .rspFault(rspFault),
    .rspPaddr(rspPaddr), .rspPerm(rspPerm), .rspVec(rspVec)
  );

  typedef struct {
    logic        fault;
    logic [31:0] paddr;
    logic [2:0]  perm;
    logic [3:0]  vec;
    int          due;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  int nRun = 0, nFail = 0, cyc = 0, extraRsp = 0, tlbDelay = 0;
  bit finished = 0;
  logic [31:0] expTlbVaddr;
  logic [1:0]  expTlbKind;
  logic        expTlbUser;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behaviour of the page TLB stand-in
  function automatic expItem_t tlbModel(logic [31:0] va, logic [1:0] k, logic u);
    expItem_t r;
    r.fault = va[12] ^ u;
    r.paddr = {va[31:13] ^ 19'h2B3C5, va[12:0]};
    r.perm  = {u, k} ^ 3'b010;
    r.vec   = va[3:0] ^ {2'b00, k};
    r.due   = -1;
    r.req   = "R8";
    return r;
  endfunction

  // TLB responder
  initial begin
    tlbDone = 0; tlbFault = 0; tlbPaddr = '0; tlbPerm = '0; tlbVec = '0;
    forever begin
      @(negedge clk);
      if (rstN && tlbReq && !tlbDone) begin
        logic [31:0] snapVa;
        logic [1:0]  snapK;
        logic        snapU;
        expItem_t    r;
        check(tlbVaddr == expTlbVaddr && tlbKind == expTlbKind && tlbUser == expTlbUser,
              "R6", "tlb request fields", {tlbVaddr, 29'd0, tlbKind, tlbUser},
              {expTlbVaddr, 29'd0, expTlbKind, expTlbUser});
        check(tlbInstr == (expTlbKind == 2'd2), "R7", "tlbInstr", 64'(tlbInstr),
              64'(expTlbKind == 2'd2));
        snapVa = tlbVaddr; snapK = tlbKind; snapU = tlbUser;
        repeat (tlbDelay) @(negedge clk);
        check(tlbVaddr == snapVa && tlbKind == snapK && tlbUser == snapU && tlbReq,
              "R6", "tlb request held", {tlbVaddr, 31'd0, tlbReq}, {snapVa, 31'd0, 1'b1});
        r = tlbModel(tlbVaddr, tlbKind, tlbUser);
        tlbFault = r.fault; tlbPaddr = r.paddr; tlbPerm = r.perm; tlbVec = r.vec;
        tlbDone = 1;
        @(negedge clk);
        tlbDone = 0;
        check(!tlbReq, "R8", "tlbReq released", 64'(tlbReq), 64'd0);
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (expQ.size() == 0) begin
          extraRsp++;
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(rspFault == e.fault && rspPaddr == e.paddr && rspPerm == e.perm && rspVec == e.vec,
                e.req, "response", {rspPaddr, 20'd0, rspVec, rspPerm, rspFault},
                {e.paddr, 20'd0, e.vec, e.perm, e.fault});
          if (e.due >= 0)
            check(cyc == e.due, e.req, "direct latency", 64'(cyc), 64'(e.due));
        end
      end
    end
  end

  function automatic expItem_t predict(logic [31:0] va, logic [1:0] k, logic u, string req);
    expItem_t e;
    logic [3:0] sg;
    logic [3:0] nib;
    sg = va[31:28];
    e.req = req;
    if ((globalCfg & 32'hC) == 0) begin
      e.fault = 0; e.paddr = va; e.perm = 3'b111; e.vec = 0; e.due = cyc + 1;
    end else if (mmuCfg[sg] && !u) begin
      nib = (sg < 8) ? 4'(baseLo >> (4 * sg)) : 4'(baseHi >> (4 * (sg - 8)));
      e.fault = 0; e.paddr = {nib, va[27:0]}; e.perm = 3'b111; e.vec = 0; e.due = cyc + 1;
    end else begin
      e = tlbModel(va, k, u);
      e.req = req;
    end
    return e;
  endfunction

  task automatic sendReq(logic [31:0] va, logic [1:0] k, logic u, string req);
    expItem_t e;
    e = predict(va, k, u, req);
    expTlbVaddr = va; expTlbKind = k; expTlbUser = u;
    expQ.push_back(e);
    vaddr = va; accKind = k; userMode = u; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rstN = 0; reqValid = 0; vaddr = '0; accKind = 0; userMode = 0;
    globalCfg = 0; mmuCfg = 0; baseLo = 0; baseHi = 0;
    repeat (3) @(negedge clk);
    check(!rspValid && !tlbReq, "R1", "reset outputs", {rspValid, tlbReq}, 64'd0);
    rstN = 1;
    @(negedge clk);
    check(!rspValid && !tlbReq, "R1", "idle after reset", {rspValid, tlbReq}, 64'd0);

    // R2: translation off
    mmuCfg = 32'hFFFF; baseLo = 32'h89AB_CDEF; baseHi = 32'h7654_3210;
    sendReq(32'h9234_5678, 2'd0, 1'b0, "R2");
    sendReq(32'h1F00_0ABC, 2'd2, 1'b1, "R2");
    globalCfg = 32'hFFFF_FFF3;
    sendReq(32'hC000_1234, 2'd1, 1'b1, "R2");

    // R3 R4: each segment direct-mapped
    globalCfg = 32'h0000_000C;
    for (int s = 0; s < 16; s++) begin
      logic [3:0] sg;
      sg = 4'(s);
      sendReq({sg, 28'h0ABC123 ^ 28'(s * 77)}, 2'(s % 3), 1'b0, (s < 8) ? "R4" : "R3");
    end

    // R2: either enable bit alone turns translation on (segment not mapped -> TLB)
    mmuCfg = 32'h0000_0400;
    globalCfg = 32'h4;
    sendReq(32'h3000_1000, 2'd0, 1'b0, "R2");
    globalCfg = 32'h8;
    sendReq(32'h3000_1000, 2'd1, 1'b0, "R2");
    sendReq(32'hA123_4567, 2'd0, 1'b0, "R3");

    // R5: user mode skips direct mapping
    sendReq(32'hA123_5567, 2'd0, 1'b1, "R5");

    // R6 R7 R8: TLB path, several kinds and delays
    tlbDelay = 0;
    sendReq(32'h5555_2AAA, 2'd2, 1'b0, "R7");
    tlbDelay = 2;
    sendReq(32'h6666_3003, 2'd1, 1'b1, "R6");
    tlbDelay = 5;
    sendReq(32'h7777_0F0F, 2'd2, 1'b1, "R8");

    // R9: back-to-back direct requests give one response each
    globalCfg = 0;
    begin
      expItem_t e1, e2;
      e1 = predict(32'h0102_0304, 2'd0, 1'b0, "R9");
      expQ.push_back(e1);
      vaddr = 32'h0102_0304; reqValid = 1;
      @(negedge clk);
      e2 = predict(32'hF0E0_D0C0, 2'd0, 1'b0, "R9");
      expQ.push_back(e2);
      vaddr = 32'hF0E0_D0C0;
      @(negedge clk);
      reqValid = 0;
      repeat (4) @(negedge clk);
      check(expQ.size() == 0 && extraRsp == 0, "R9", "response count",
            64'(expQ.size() + extraRsp), 64'd0);
    end

    // R10: requests held through a TLB wait, including the done cycle
    globalCfg = 32'hC; mmuCfg = 0; tlbDelay = 3;
    begin
      expItem_t e;
      e = predict(32'h4242_8888, 2'd0, 1'b1, "R10");
      expTlbVaddr = 32'h4242_8888; expTlbKind = 2'd0; expTlbUser = 1'b1;
      expQ.push_back(e);
      vaddr = 32'h4242_8888; accKind = 0; userMode = 1; reqValid = 1;
      @(negedge clk);
      check(tlbReq, "R10", "lookup started", 64'(tlbReq), 64'd1);
      globalCfg = 0; userMode = 0; vaddr = 32'h1357_9BDF;
      repeat (3) @(negedge clk);
      @(negedge clk);
      reqValid = 0;
      repeat (5) @(negedge clk);
      check(expQ.size() == 0 && extraRsp == 0 && !tlbReq, "R10", "stray request",
            64'(expQ.size() + extraRsp + tlbReq), 64'd0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "R9", "watchdog expired", 64'(cyc), 64'd0);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule